// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of several DMA channels is serviced next. Every channel has a hardware request pin whose active level is selectable, plus a software request bit held inside the block. The two sources are OR-combined, and a per-channel mask gates the result. From the channels that remain eligible, the arbiter picks one under either a fixed order or a rotating order. It then registers that choice as a grant and holds it until the transfer engine reports completion with a one-cycle done pulse.

The transfer engine reads the grant as a one-hot vector and as a binary channel number. The acknowledge outputs repeat the one-hot grant at a selectable polarity. Each done pulse records the serviced channel, which is the reference point for rotation, and clears that channel's software request bit. A disable input prevents any new grant from being issued. A grant that is already held runs until its done pulse arrives.

Top module: `dmaarb_top`

## Requirements
- R1: After reset, `grant_vld` is 0, `grant_oh` is all zeros, `dack` shows every channel inactive, all software request bits are 0, and the rotation reference is channel NCH-1, so channel 0 ranks highest.
- R2: With `cfg_rotate`=0 and the arbiter idle, the lowest-numbered eligible channel is granted on the next clock edge. A channel is eligible when it is requesting and its `mask` bit is 0.
- R3: With `cfg_rotate`=1, the search for the next grant starts at the channel one above the last channel that received a done pulse and wraps from NCH-1 to 0, so the serviced channel ranks lowest.
- R4: Once `grant_vld` is 1, the grant and channel number hold unchanged, whatever requests, masks or disable do, until a done pulse arrives.
- R5: With `cfg_dreq_low`=0 a `dreq_pin` bit at 1 is a request. With `cfg_dreq_low`=1 a pin at 0 is a request.
- R6: Each `dack` bit equals the matching `grant_oh` bit when `cfg_dack_low`=0 and its inverse when `cfg_dack_low`=1.
- R7: A channel whose `mask` bit is 1 is never newly granted, even when its pin or its software bit is requesting.
- R8: A write with `swreq_we`=1 sets (`swreq_set`=1) or clears (`swreq_set`=0) the software request bit of channel `swreq_ch`. A set bit counts as a request, and a done pulse for that channel clears it. If a write and a done pulse reach the same channel in the same cycle, the write wins.
- R9: While `cfg_disable`=1, no new grant is issued.
- R10: `grant_oh` has exactly one bit set when `grant_vld`=1 and is zero otherwise, and `grant_num` is that bit's index. After a done pulse, `grant_vld` is 0 for at least the following cycle, and a done pulse with no grant held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rotate | input | 1 | 1 selects rotating priority, 0 selects fixed |
| cfg_disable | input | 1 | 1 blocks new grants |
| cfg_dreq_low | input | 1 | 1 makes request pins active low |
| cfg_dack_low | input | 1 | 1 makes acknowledge outputs active low |
| dreq_pin | input | NCH | Hardware request pins |
| mask | input | NCH | Per-channel mask, 1 blocks the channel |
| swreq_we | input | 1 | Software request write strobe |
| swreq_ch | input | log2(NCH) | Channel addressed by the write |
| swreq_set | input | 1 | Value written to the software request bit |
| done | input | 1 | One-cycle pulse: the granted transfer has finished |
| grant_vld | output | 1 | A grant is held |
| grant_oh | output | NCH | One-hot granted channel |
| grant_num | output | log2(NCH) | Binary granted channel |
| dack | output | NCH | Acknowledge per channel at the chosen polarity |

## Verification
The bench sweeps every combination of request and mask in fixed order. A picker that ignored the mask, or that searched from the top of the channel list, would grant the wrong channel. In rotating mode it first places the rotation reference on each channel and then applies every nonzero request pattern, so a picker that forgot to wrap, or that started at the serviced channel rather than the one after it, would be caught. It also holds a grant while the requests under it change, which exposes any design that re-arbitrates during a service. It checks both polarities, the clearing of software requests on done, disable, and a reset in the middle of a rotation, which a design that did not restore the order would still bias.

// File: rtl/dmaarb_pkg.sv
// Package: shared configuration type for the DMA channel arbiter.
// Assumes nothing beyond being compiled before the modules that import it.
package dmaarb_pkg;

    // Arbitration and polarity settings gathered into one word.
    typedef struct packed {
        logic rotate;
        logic disable_all;
        logic dreq_low;
        logic dack_low;
    } arb_cfg_t;

endpackage

// File: rtl/dmaarb_req_merge.sv
// Request merge: turns pin levels into active-high requests, holds a
// software request bit for each channel, ORs the two sources and gates
// the result with the mask.
// Assumes: writes and done-clears arrive as single-cycle strobes.
module dmaarb_req_merge #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dreq_low,
    input  logic [NCH-1:0] dreq_pin,
    input  logic [NCH-1:0] mask,
    input  logic           swreq_we,
    input  logic [CW-1:0]  swreq_ch,
    input  logic           swreq_set,
    input  logic           clr_vld,
    input  logic [CW-1:0]  clr_ch,
    output logic [NCH-1:0] elig
);

    logic [NCH-1:0] sw_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Software request bit: a write takes precedence over the done-clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sw_q[i] <= 1'b0;
            end else if (swreq_we && (swreq_ch == CW'(i))) begin
                sw_q[i] <= swreq_set;
            end else if (clr_vld && (clr_ch == CW'(i))) begin
                sw_q[i] <= 1'b0;
            end
        end

        // Eligibility: a pin request or software request, unless masked.
        always_comb begin
            elig[i] = ((dreq_pin[i] ^ dreq_low) | sw_q[i]) & ~mask[i];
        end
    end

endmodule

// File: rtl/dmaarb_pick.sv
// Priority picker: a combinational search of the eligible vector that
// starts one above a base channel and wraps. Fixed order uses base NCH-1,
// so channel 0 is searched first.
// Assumes: NCH >= 2; last is a valid channel index.
module dmaarb_pick #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] elig,
    input  logic [CW-1:0]  last,
    input  logic           rotate,
    output logic           found,
    output logic [CW-1:0]  pick
);

    logic [CW-1:0] base;

    // Search base: the rotation reference, or the top channel for fixed order.
    always_comb begin
        base = rotate ? last : CW'(NCH - 1);
    end

    // Wrapped search: scanning from far to near leaves the nearest hit in pick.
    always_comb begin
        int idx;
        pick  = '0;
        found = |elig;
        for (int k = NCH; k >= 1; k--) begin
            idx = (int'(base) + k) % NCH;
            if (elig[idx]) begin
                pick = CW'(idx);
            end
        end
    end

endmodule

// File: rtl/dmaarb_top.sv
// DMA channel priority arbiter top. Registers one grant at a time, holds it
// until done, updates the rotation reference on done and drives acknowledge
// outputs at the chosen polarity.
// Assumes: done is a single-cycle pulse that is meaningful only while a
// grant is held; configuration inputs are quasi-static.
module dmaarb_top #(
    parameter int NCH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_rotate,
    input  logic                   cfg_disable,
    input  logic                   cfg_dreq_low,
    input  logic                   cfg_dack_low,
    input  logic [NCH-1:0]         dreq_pin,
    input  logic [NCH-1:0]         mask,
    input  logic                   swreq_we,
    input  logic [$clog2(NCH)-1:0] swreq_ch,
    input  logic                   swreq_set,
    input  logic                   done,
    output logic                   grant_vld,
    output logic [NCH-1:0]         grant_oh,
    output logic [$clog2(NCH)-1:0] grant_num,
    output logic [NCH-1:0]         dack
);

    import dmaarb_pkg::*;

    localparam int CW = $clog2(NCH);

    arb_cfg_t       cfg;
    logic [NCH-1:0] elig;
    logic           found;
    logic [CW-1:0]  pick;
    logic           vld_q;
    logic [CW-1:0]  num_q;
    logic [CW-1:0]  last_q;
    logic           fin;

    // Gather the configuration pins into one word.
    always_comb begin
        cfg.rotate      = cfg_rotate;
        cfg.disable_all = cfg_disable;
        cfg.dreq_low    = cfg_dreq_low;
        cfg.dack_low    = cfg_dack_low;
    end

    // A done pulse ends a service only while a grant is held.
    always_comb begin
        fin = vld_q & done;
    end

    dmaarb_req_merge #(.NCH(NCH)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .dreq_low  (cfg.dreq_low),
        .dreq_pin  (dreq_pin),
        .mask      (mask),
        .swreq_we  (swreq_we),
        .swreq_ch  (swreq_ch),
        .swreq_set (swreq_set),
        .clr_vld   (fin),
        .clr_ch    (num_q),
        .elig      (elig)
    );

    dmaarb_pick #(.NCH(NCH)) u_pick (
        .elig   (elig),
        .last   (last_q),
        .rotate (cfg.rotate),
        .found  (found),
        .pick   (pick)
    );

    // Grant state: hold until done, otherwise take a new winner when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            num_q  <= '0;
            last_q <= CW'(NCH - 1);
        end else if (vld_q) begin
            if (done) begin
                vld_q  <= 1'b0;
                last_q <= num_q;
            end
        end else if (found && !cfg.disable_all) begin
            vld_q <= 1'b1;
            num_q <= pick;
        end
    end

    // Output decode: one-hot grant and polarity-adjusted acknowledge.
    always_comb begin
        grant_oh  = '0;
        if (vld_q) begin
            grant_oh[num_q] = 1'b1;
        end
        grant_vld = vld_q;
        grant_num = num_q;
        dack      = grant_oh ^ {NCH{cfg.dack_low}};
    end

endmodule

// File: rtl/dmaarb_chk.sv
// Checker for the DMA arbiter: temporal properties on the top-level ports.
// Assumes: attached to every instance of dmaarb_top through the bind below.
module dmaarb_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_disable,
    input logic [NCH-1:0] mask,
    input logic           done,
    input logic           grant_vld,
    input logic [NCH-1:0] grant_oh
);

    // R4: a held grant stays put until done.
    a_r4_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !done) |=> (grant_vld && $stable(grant_oh)));

    // R10: one-hot while valid.
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> ($countones(grant_oh) == 1));

    // R10: no stray grant bit while idle.
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |-> (grant_oh == '0));

    // R10: a gap of at least one cycle after done.
    a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && done) |=> !grant_vld);

    // R9: disable while idle keeps the arbiter idle.
    a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && cfg_disable) |=> !grant_vld);

    // R7: a new grant never lands on a channel masked when it was chosen.
    a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && !cfg_disable) |=> (!grant_vld || ((grant_oh & $past(mask)) == '0)));

endmodule

bind dmaarb_top dmaarb_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_disable (cfg_disable),
    .mask        (mask),
    .done        (done),
    .grant_vld   (grant_vld),
    .grant_oh    (grant_oh)
);

// File: tb/test_dmaarb_top.sv
module test_dmaarb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_rotate = 1'b0;
    logic       cfg_disable = 1'b0;
    logic       cfg_dreq_low = 1'b0;
    logic       cfg_dack_low = 1'b0;
    logic [3:0] dreq_pin = 4'h0;
    logic [3:0] mask = 4'hF;
    logic       swreq_we = 1'b0;
    logic [1:0] swreq_ch = 2'd0;
    logic       swreq_set = 1'b0;
    logic       done = 1'b0;
    logic       grant_vld;
    logic [3:0] grant_oh;
    logic [1:0] grant_num;
    logic [3:0] dack;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dmaarb_top #(.NCH(4)) i_dmaarb_top (
        .clk (clk), .rst_n (rst_n), .cfg_rotate (cfg_rotate),
        .cfg_disable (cfg_disable), .cfg_dreq_low (cfg_dreq_low),
        .cfg_dack_low (cfg_dack_low), .dreq_pin (dreq_pin), .mask (mask),
        .swreq_we (swreq_we), .swreq_ch (swreq_ch), .swreq_set (swreq_set),
        .done (done), .grant_vld (grant_vld), .grant_oh (grant_oh),
        .grant_num (grant_num), .dack (dack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // First set bit of a 4-bit pattern, searching upward from start with wrap.
    function automatic int first_from(input int bits, input int start);
        for (int k = 0; k < 4; k++) begin
            int idx = (start + k) % 4;
            if (bits[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic expect_grant(input string tag, input int exp);
        if (exp < 0) begin
            chk(tag, int'(grant_vld), 0);
        end else begin
            chk(tag, int'(grant_vld), 1);
            chk(tag, int'(grant_num), exp);
            chk({tag, " R10 onehot"}, int'(grant_oh), 1 << exp);
        end
    endtask

    // Pulse done for one cycle and confirm the grant drops (R10).
    task automatic finish_service();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        dreq_pin = cfg_dreq_low ? 4'hF : 4'h0;
        mask = 4'hF;
        chk("R10 drop after done", int'(grant_vld), 0);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        dreq_pin = 4'h0;
        mask = 4'hF;
        done = 1'b0;
        swreq_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 grant_vld", int'(grant_vld), 0);
        chk("R1 grant_oh", int'(grant_oh), 0);
        chk("R1 dack", int'(dack), 0);

        // R2, R7, R4: every request pattern against every mask, fixed order
        for (int r = 0; r < 16; r++) begin
            for (int m = 0; m < 16; m++) begin
                int e;
                e = first_from(r & ~m, 0);
                dreq_pin = 4'(r);
                mask = 4'(m);
                @(negedge clk);
                expect_grant("R2/R7 fixed", e);
                if (e >= 0) begin
                    dreq_pin = 4'hF;
                    mask = 4'h0;
                    @(negedge clk);
                    chk("R4 held", int'(grant_num), e);
                    finish_service();
                end else begin
                    dreq_pin = 4'h0;
                    mask = 4'hF;
                    @(negedge clk);
                end
            end
        end

        // R3: rotation from each reference channel, all request patterns
        cfg_rotate = 1'b1;
        for (int c = 0; c < 4; c++) begin
            for (int r = 1; r < 16; r++) begin
                mask = 4'h0;
                dreq_pin = 4'(1 << c);
                @(negedge clk);
                expect_grant("R3 prime", c);
                finish_service();
                mask = 4'h0;
                dreq_pin = 4'(r);
                @(negedge clk);
                expect_grant("R3 rotate", first_from(r, c + 1));
                finish_service();
            end
        end

        // R3: channels 1 and 2 requesting from the reset order
        do_reset();
        mask = 4'h0;
        dreq_pin = 4'b0110;
        @(negedge clk);
        expect_grant("R3 example first", 1);
        done = 1'b1; @(negedge clk); done = 1'b0;
        @(negedge clk);
        expect_grant("R3 example second", 2);
        done = 1'b1; @(negedge clk); done = 1'b0;
        dreq_pin = 4'hF;
        @(negedge clk);
        expect_grant("R3 example third", 3);
        finish_service();

        // R1: reset restores channel 0 as highest even in rotating mode
        mask = 4'h0; dreq_pin = 4'b0001;
        @(negedge clk);
        finish_service();
        do_reset();
        mask = 4'h0; dreq_pin = 4'b0011;
        @(negedge clk);
        expect_grant("R1 order after reset", 0);
        finish_service();
        cfg_rotate = 1'b0;

        // R5: active-low request pins
        cfg_dreq_low = 1'b1;
        dreq_pin = 4'hF;
        for (int r = 0; r < 16; r++) begin
            mask = 4'h0;
            dreq_pin = ~4'(r);
            @(negedge clk);
            expect_grant("R5 low pins", first_from(r, 0));
            if (r != 0) finish_service();
            else begin dreq_pin = 4'hF; @(negedge clk); end
        end
        cfg_dreq_low = 1'b0;
        dreq_pin = 4'h0;

        // R6: acknowledge polarity in both settings
        mask = 4'h0; dreq_pin = 4'b0100;
        @(negedge clk);
        chk("R6 dack high", int'(dack), 4'b0100);
        cfg_dack_low = 1'b1;
        @(negedge clk);
        chk("R6 dack low", int'(dack), 4'b1011);
        finish_service();
        chk("R6 dack low idle", int'(dack), 4'hF);
        cfg_dack_low = 1'b0;

        // R8: software request set, served, then cleared by done
        mask = 4'h0; dreq_pin = 4'h0;
        swreq_we = 1'b1; swreq_ch = 2'd2; swreq_set = 1'b1;
        @(negedge clk);
        swreq_we = 1'b0;
        @(negedge clk);
        expect_grant("R8 sw grant", 2);
        finish_service();
        mask = 4'h0;
        repeat (2) @(negedge clk);
        expect_grant("R8 sw cleared by done", -1);

        // R8: set then clear by write leaves no request
        swreq_we = 1'b1; swreq_ch = 2'd3; swreq_set = 1'b1;
        @(negedge clk);
        mask = 4'hF;
        swreq_set = 1'b0;
        @(negedge clk);
        swreq_we = 1'b0;
        mask = 4'h0;
        repeat (2) @(negedge clk);
        expect_grant("R8 sw write clear", -1);

        // R7: masked software request is ignored until unmasked
        mask = 4'b0010;
        swreq_we = 1'b1; swreq_ch = 2'd1; swreq_set = 1'b1;
        @(negedge clk);
        swreq_we = 1'b0;
        repeat (2) @(negedge clk);
        expect_grant("R7 masked sw", -1);
        mask = 4'h0;
        @(negedge clk);
        expect_grant("R7 unmasked sw", 1);
        finish_service();

        // R9: disable blocks new grants, release lets them through
        cfg_disable = 1'b1;
        mask = 4'h0; dreq_pin = 4'hF;
        repeat (3) @(negedge clk);
        expect_grant("R9 disabled", -1);
        cfg_disable = 1'b0;
        @(negedge clk);
        expect_grant("R9 enabled", 0);
        // R4: disable does not drop a held grant
        cfg_disable = 1'b1;
        @(negedge clk);
        expect_grant("R4 held under disable", 0);
        finish_service();
        cfg_disable = 1'b0;

        // R10: stray done while idle changes nothing
        done = 1'b1; @(negedge clk); done = 1'b0;
        mask = 4'h0; dreq_pin = 4'b1000;
        @(negedge clk);
        expect_grant("R10 stray done", 3);
        finish_service();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule